// File: doc/BRIEF.md
# Serial Chroma Frequency-Word Transmitter

This block sends a chroma PLL frequency word, one bit at a time, to a companion video encoder so that the encoder can lock its colour subcarrier. It runs in the fast genlock clock domain. Inside, a divide-by-four enable marks the serial clock, and every line transition lands on one of these serial-clock boundaries. A frame has six parts in this order: a start marker (low, then high), the upper 22 bits of the frequency word sent MSB first at two serial clocks per bit, six idle-high serial clocks, an active-low encoder reset bit, and two idle-high serial clocks. The next frame starts right after the last of these.

The caller supplies the upper 21 bits of the frequency word. The LSB of the payload is not taken from the word. A configuration input (`lsb_force`) supplies it instead; the usual setting is 1. At the start of every frame the block captures the word, the LSB setting and the encoder reset request. A mode input selects what drives the device pin. When it is high, the pin carries the serial frame. When it is low, the pin carries a plain genlock signal, the serial line is held high and the sequencer returns to idle. The input `rst_n` is an asynchronous active-low reset whose release must already be synchronised to `clk`.

Top module: `rtc_freq_tx`

## Requirements
- R1: While the serial mode is selected, `ser_o` changes value only on serial-clock boundaries, and one serial clock lasts exactly 4 `clk` cycles.
- R2: Each frame opens with `ser_o` low for one serial clock and then high for one serial clock.
- R3: After the marker, the 22 payload bits are sent MSB first. Payload bit 21 comes from `freq_msbs[21]` and payload bit 1 from `freq_msbs[1]`. Each bit holds for 2 serial clocks.
- R4: The last payload bit sent (bit 0) equals `lsb_force`, whatever the rest of the word holds.
- R5: After the last payload bit, `ser_o` stays high for 6 serial clocks. It then carries the reset bit for 2 serial clocks. The reset bit is low when `enc_rst_req` was 1 at frame start and high when it was 0.
- R6: After the reset bit, `ser_o` stays high for 2 serial clocks, and the next frame begins at once. A frame lasts 56 serial clocks (224 `clk` cycles).
- R7: The word, `lsb_force` and `enc_rst_req` are captured at the `clk` edge that starts a frame. Changes made during a frame have no effect on that frame.
- R8: While `ser_mode` is 0, `ser_o` is 1 and `pin_o` follows `glco_in`. While `ser_mode` is 1, `pin_o` equals `ser_o`.
- R9: During reset, `ser_o` is 1.
- R10: Count `clk` edges from the first edge at which `rst_n` and `ser_mode` are both sampled high, calling that edge 1. The first frame is captured at edge 4, and its marker low appears on `ser_o` after edge 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Genlock clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freq_msbs | input | 21 | Payload bits 21..1 (upper bits of the frequency word) |
| lsb_force | input | 1 | Value sent as payload bit 0 |
| enc_rst_req | input | 1 | 1 requests an encoder reset (reset bit sent low) |
| ser_mode | input | 1 | 1 selects the serial frame on the pin, 0 the genlock signal |
| glco_in | input | 1 | Plain genlock signal routed to the pin when not in serial mode |
| ser_o | output | 1 | Serial frame line, registered, idles high |
| pin_o | output | 1 | Device pin after mode selection |

## Verification
The checker watches four things on every cycle:
- the serial-clock enable fires exactly every four cycles;
- a deselected mode drives the line high on the next cycle;
- every frame start is followed by the marker low;
- every frame spans exactly 56 serial clocks and 21 shift steps.

The bit values cannot be checked that way, because they depend on captured inputs. These include payload order, the forced LSB, the polarity of the reset bit, the isolation of a frame from mid-frame input changes, and the genlock pass-through. The bench's reference model covers them by comparing both outputs on every cycle across several words, settings and mode toggles.

// File: rtl/rtc_tx_pkg.sv
package rtc_tx_pkg;

  // Frame phases of the serial transmitter, in transmission order.
  typedef enum logic [2:0] {
    PH_MARK_LO = 3'd0,
    PH_MARK_HI = 3'd1,
    PH_DATA    = 3'd2,
    PH_GAP     = 3'd3,
    PH_RSTB    = 3'd4,
    PH_TAIL    = 3'd5
  } rtc_phase_e;

endpackage

// File: rtl/rtc_bitclk_div.sv
module rtc_bitclk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/rtc_frame_seq.sv
module rtc_frame_seq
  import rtc_tx_pkg::*;
#(
  parameter int PAY_W      = 22,
  parameter int BIT_SLOTS  = 2,
  parameter int GAP_SLOTS  = 6,
  parameter int RSTB_SLOTS = 2,
  parameter int TAIL_SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  output rtc_phase_e ph,
  output logic       load,
  output logic       shift
);

  localparam int M1   = (BIT_SLOTS > GAP_SLOTS) ? BIT_SLOTS : GAP_SLOTS;
  localparam int M2   = (RSTB_SLOTS > TAIL_SLOTS) ? RSTB_SLOTS : TAIL_SLOTS;
  localparam int MAXS = (M1 > M2) ? M1 : M2;
  localparam int CW   = (MAXS > 1) ? $clog2(MAXS) : 1;
  localparam int BW   = (PAY_W > 1) ? $clog2(PAY_W) : 1;

  rtc_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bits_q, bits_d;
  logic          unit_end;

  assign unit_end = (cnt_q == '0);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    bits_d = bits_q;
    if (!en) begin
      ph_d   = PH_TAIL;
      cnt_d  = '0;
      bits_d = '0;
    end else if (tick) begin
      if (!unit_end) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        unique case (ph_q)
          PH_MARK_LO: begin
            ph_d  = PH_MARK_HI;
            cnt_d = '0;
          end
          PH_MARK_HI: begin
            ph_d   = PH_DATA;
            cnt_d  = CW'(BIT_SLOTS - 1);
            bits_d = BW'(PAY_W - 1);
          end
          PH_DATA: begin
            if (bits_q != '0) begin
              bits_d = bits_q - 1'b1;
              cnt_d  = CW'(BIT_SLOTS - 1);
            end else begin
              ph_d  = PH_GAP;
              cnt_d = CW'(GAP_SLOTS - 1);
            end
          end
          PH_GAP: begin
            ph_d  = PH_RSTB;
            cnt_d = CW'(RSTB_SLOTS - 1);
          end
          PH_RSTB: begin
            ph_d  = PH_TAIL;
            cnt_d = CW'(TAIL_SLOTS - 1);
          end
          default: begin
            ph_d  = PH_MARK_LO;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_TAIL;
      cnt_q  <= '0;
      bits_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      bits_q <= bits_d;
    end
  end

  assign ph    = ph_q;
  assign load  = en && tick && (ph_q == PH_TAIL) && unit_end;
  assign shift = en && tick && (ph_q == PH_DATA) && unit_end && (bits_q != '0);

endmodule

// File: rtl/rtc_word_shift.sv
module rtc_word_shift #(
  parameter int PAY_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [PAY_W-1:0] payload,
  output logic             msb
);

  logic [PAY_W-1:0] sh_q, sh_d;

  always_comb begin
    if (load) begin
      sh_d = payload;
    end else if (shift) begin
      sh_d = {sh_q[PAY_W-2:0], 1'b0};
    end else begin
      sh_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign msb = sh_q[PAY_W-1];

endmodule

// File: rtl/rtc_freq_tx.sv
module rtc_freq_tx
  import rtc_tx_pkg::*;
#(
  parameter int PAY_W      = 22,
  parameter int DIV        = 4,
  parameter int BIT_SLOTS  = 2,
  parameter int GAP_SLOTS  = 6,
  parameter int RSTB_SLOTS = 2,
  parameter int TAIL_SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAY_W-1:1] freq_msbs,
  input  logic             lsb_force,
  input  logic             enc_rst_req,
  input  logic             ser_mode,
  input  logic             glco_in,
  output logic             ser_o,
  output logic             pin_o
);

  localparam int FRAME = 2 + PAY_W * BIT_SLOTS + GAP_SLOTS + RSTB_SLOTS + TAIL_SLOTS;

  logic             tick;
  logic             load;
  logic             shift;
  logic             data_bit;
  rtc_phase_e       ph;
  logic [PAY_W-1:0] payload;
  logic             rstb_q, rstb_d;
  logic             line_c;
  logic             ser_q, ser_d;

  assign payload = {freq_msbs, lsb_force};

  rtc_bitclk_div #(
    .DIV (DIV)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ser_mode),
    .tick  (tick)
  );

  rtc_frame_seq #(
    .PAY_W      (PAY_W),
    .BIT_SLOTS  (BIT_SLOTS),
    .GAP_SLOTS  (GAP_SLOTS),
    .RSTB_SLOTS (RSTB_SLOTS),
    .TAIL_SLOTS (TAIL_SLOTS)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ser_mode),
    .tick  (tick),
    .ph    (ph),
    .load  (load),
    .shift (shift)
  );

  rtc_word_shift #(
    .PAY_W (PAY_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .shift   (shift),
    .payload (payload),
    .msb     (data_bit)
  );

  // Reset-bit level captured with the word; active low toward the encoder.
  assign rstb_d = load ? ~enc_rst_req : rstb_q;

  always_comb begin
    unique case (ph)
      PH_MARK_LO: line_c = 1'b0;
      PH_MARK_HI: line_c = 1'b1;
      PH_DATA:    line_c = data_bit;
      PH_RSTB:    line_c = rstb_q;
      default:    line_c = 1'b1;
    endcase
  end

  assign ser_d = ser_mode ? line_c : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstb_q <= 1'b1;
      ser_q  <= 1'b1;
    end else begin
      rstb_q <= rstb_d;
      ser_q  <= ser_d;
    end
  end

  assign ser_o = ser_q;
  assign pin_o = ser_mode ? ser_q : glco_in;

endmodule

// File: rtl/rtc_freq_tx_chk.sv
module rtc_freq_tx_chk #(
  parameter int DIV   = 4,
  parameter int PAY_W = 22,
  parameter int FRAME = 56
) (
  input logic clk,
  input logic rst_n,
  input logic ser_mode,
  input logic ser_o,
  input logic tick,
  input logic load,
  input logic shift
);

  logic [7:0]  gap_q;
  logic [15:0] tcnt_q;
  logic [15:0] scnt_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      tcnt_q <= '0;
      scnt_q <= '0;
      seen_q <= 1'b0;
    end else if (!ser_mode) begin
      gap_q  <= '0;
      tcnt_q <= '0;
      scnt_q <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q <= tick ? 8'd0 : gap_q + 8'd1;
      if (load) begin
        tcnt_q <= '0;
        scnt_q <= '0;
        seen_q <= 1'b1;
      end else begin
        if (tick)  tcnt_q <= tcnt_q + 16'd1;
        if (shift) scnt_q <= scnt_q + 16'd1;
      end
    end
  end

  // R1: the serial clock enable is spaced DIV genlock cycles apart
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == 8'(DIV - 1)));

  // R8: deselecting the serial mode drives the line high next cycle
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode |=> ser_o);

  // R2: a frame start is followed by the low half of the marker
  p_mark_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load ##1 ser_mode |=> !ser_o);

  // R3: one shift per payload bit boundary within a frame
  p_shift_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seen_q) |-> (scnt_q == 16'(PAY_W - 1)));

  // R6: consecutive frame starts are FRAME serial clocks apart
  p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seen_q) |-> (tcnt_q == 16'(FRAME - 1)));

endmodule

bind rtc_freq_tx rtc_freq_tx_chk #(
  .DIV   (DIV),
  .PAY_W (PAY_W),
  .FRAME (FRAME)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_mode (ser_mode),
  .ser_o    (ser_o),
  .tick     (tick),
  .load     (load),
  .shift    (shift)
);

// File: tb/tb_rtc_freq_tx.sv
`timescale 1ns/1ps
module tb_rtc_freq_tx;

  localparam int PAY   = 22;
  localparam int NSL   = 56;
  localparam int FCLK  = NSL * 4;

  logic          clk;
  logic          rst_n;
  logic [PAY-1:1] freq_msbs;
  logic          lsb_force;
  logic          enc_rst_req;
  logic          ser_mode;
  logic          glco_in;
  logic          ser_o;
  logic          pin_o;

  int tests;
  int fails;
  bit chk_en;
  bit r7_win;

  // reference model state
  int             e;
  logic [PAY-1:1] mw;
  logic           mf;
  logic           mr;
  logic           exp_ser;
  logic           prev_ser;

  rtc_freq_tx dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .freq_msbs   (freq_msbs),
    .lsb_force   (lsb_force),
    .enc_rst_req (enc_rst_req),
    .ser_mode    (ser_mode),
    .glco_in     (glco_in),
    .ser_o       (ser_o),
    .pin_o       (pin_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic ser_at(int n);
    int s;
    logic [PAY-1:0] pay;
    pay = {mw, mf};
    if (n < 5) return 1'b1;
    s = ((n - 5) / 4) % NSL;
    if (s == 0) return 1'b0;
    if (s == 1) return 1'b1;
    if (s < 2 + 2 * PAY) return pay[PAY - 1 - (s - 2) / 2];
    if (s < 52) return 1'b1;
    if (s < 54) return ~mr;
    return 1'b1;
  endfunction

  function automatic string tag_at(int n);
    int s;
    if (!ser_mode) return "R8";
    if (n < 5) return "R10";
    if (r7_win) return "R7";
    s = ((n - 5) / 4) % NSL;
    if (s < 2) return (n < 13) ? "R10" : "R2";
    if (s >= 44 && s < 46) return "R4";
    if (s < 46) return "R3";
    if (s < 54) return "R5";
    return "R6";
  endfunction

  task automatic chk(input logic act, input logic expv, input string tag);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s at t=%0t: actual=%b expected=%b", tag, $time, act, expv);
    end
  endtask

  // behavioural model, advanced on every clock edge
  always @(posedge clk) begin
    if (!rst_n || !ser_mode) begin
      e       = 0;
      exp_ser = 1'b1;
    end else begin
      e = e + 1;
      if (e >= 4 && ((e - 4) % FCLK) == 0) begin
        mw = freq_msbs;
        mf = lsb_force;
        mr = enc_rst_req;
      end
      exp_ser = ser_at(e);
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      chk(ser_o, exp_ser, tag_at(e));
      chk(pin_o, ser_mode ? exp_ser : glco_in, ser_mode ? tag_at(e) : "R8");
      if (ser_mode && e > 5 && ser_o !== prev_ser) begin
        // R1: transitions fall on serial clock boundaries
        tests++;
        if (((e - 5) % 4) != 0) begin
          fails++;
          $display("FAIL R1 at t=%0t: actual=phase %0d expected=phase 0", $time, (e - 5) % 4);
        end
      end
      prev_ser = ser_o;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests       = 0;
    fails       = 0;
    chk_en      = 1'b0;
    r7_win      = 1'b0;
    prev_ser    = 1'b1;
    rst_n       = 1'b0;
    freq_msbs   = 21'h155555;
    lsb_force   = 1'b1;
    enc_rst_req = 1'b0;
    ser_mode    = 1'b1;
    glco_in     = 1'b0;
    wait_cycles(3);
    // R9: reset state
    chk(ser_o, 1'b1, "R9");
    chk(pin_o, 1'b1, "R9");
    rst_n  = 1'b1;
    chk_en = 1'b1;

    // alternating word, LSB forced high, no encoder reset
    wait_cycles(2 * FCLK + 10);

    // other pattern, LSB forced low, encoder reset requested
    freq_msbs   = 21'h0F0F0F;
    lsb_force   = 1'b0;
    enc_rst_req = 1'b1;
    wait_cycles(2 * FCLK);

    // R7: change inputs in the middle of a frame
    while (((e - 4) % FCLK) != 100) @(negedge clk);
    #1;
    r7_win      = 1'b1;
    freq_msbs   = 21'h1ABCDE;
    lsb_force   = 1'b1;
    enc_rst_req = 1'b0;
    while (((e - 4) % FCLK) != 0) @(negedge clk);
    #1;
    r7_win = 1'b0;
    wait_cycles(FCLK + 20);

    // R8: mode deselected mid-frame, genlock passes through
    ser_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      glco_in = ~glco_in;
      wait_cycles(3);
    end

    // R10: reselect, all ones with LSB forced low
    freq_msbs   = '1;
    lsb_force   = 1'b0;
    enc_rst_req = 1'b1;
    ser_mode    = 1'b1;
    wait_cycles(2 * FCLK);

    // all zeros with LSB forced high
    freq_msbs   = '0;
    lsb_force   = 1'b1;
    enc_rst_req = 1'b0;
    wait_cycles(2 * FCLK + 30);

    chk_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule